// File: doc/BRIEF.md
# Two-Way Set-Associative Write-Through Cache Controller

This controller sits between a processor-side word port and a slower main-memory port. It caches a 16-bit byte address space in 128 lines of 16 bytes. The lines form 64 sets of two ways. A read that hits is answered in the cycle it is presented. A read that misses refills the whole line from memory as four sequential 32-bit beats. The requested word can be handed back early, on the beat that carries it. Writes always go to memory. They update the cached copy only when the line is already present, and they never bring a line in.

Two mechanisms remove lines. A whole-cache invalidate input is meant for context switches. A snoop input names a block that another agent has modified, and the line holding that block is dropped. When both ways of a set are valid, the victim way comes from an external replacement unit. The controller reports every line it uses so that unit can track recency.

Top module: `assoc2_cache_ctl`

## Requirements
- R1: A byte address is split as tag = bits [15:10], set = bits [9:4], word within line = bits [3:2]. Bits [1:0] do not select a cache word.
- R2: A read to a valid line with a matching tag completes with `cpu_done` in the same cycle and causes no memory beat. It returns the cached word, including a word that an earlier write hit changed.
- R3: A read miss issues exactly four read beats to the line's base address, then base+4, base+8 and base+12, in that order. The line is valid afterwards.
- R4: With early forwarding enabled (the default), a read miss signals `cpu_done` on the beat whose word index equals the requested word and returns that beat's data. The refill then runs to its end, and the next request waits until it has finished.
- R5: A write hit performs one memory write with the word and its address, and it updates the cached word.
- R6: A write miss performs one memory write and allocates no line, so a later read of that block misses.
- R7: On a refill, way 0 is used if it is invalid, otherwise way 1 if it is invalid. Only when both are valid does `victim_way` pick the way.
- R8: One cycle of `flush` leaves every line invalid.
- R9: A snoop names a block through `snoop_blk` (address bits [15:4]). It invalidates the line holding that block, and it leaves lines of other tags in the same set untouched.
- R10: A snoop that names the block being refilled, or a flush, arriving during a refill leaves the refilled line invalid.
- R11: While `mem_req` is high and `mem_rdy` is low, `mem_req`, `mem_we` and `mem_addr` hold their values.
- R12: After reset no memory request is pending, no access is reported done, and every line is invalid.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| cpu_req | input | 1 | Access request, held until `cpu_done` |
| cpu_we | input | 1 | 1 = write, 0 = read |
| cpu_addr | input | 16 | Byte address of the access |
| cpu_wdata | input | 32 | Write word |
| cpu_rdata | output | 32 | Read word, valid with `cpu_done` |
| cpu_done | output | 1 | Access completes this cycle |
| mem_req | output | 1 | Memory beat request |
| mem_we | output | 1 | Memory beat is a write |
| mem_addr | output | 16 | Memory byte address |
| mem_wdata | output | 32 | Memory write word |
| mem_rdata | input | 32 | Memory read word, valid with `mem_rdy` |
| mem_rdy | input | 1 | Memory beat completes this cycle |
| flush | input | 1 | Invalidate every line |
| snoop_vld | input | 1 | Snoop invalidate strobe |
| snoop_blk | input | 12 | Block address (tag and set) being invalidated |
| victim_way | input | 1 | Way chosen by the replacement unit |
| rpl_touch | output | 1 | A line was used this cycle |
| rpl_set | output | 6 | Set of the used line |
| rpl_way | output | 1 | Way of the used line |

## Verification
The riskiest overlap is an invalidation that lands while a refill is still writing its line. The read has already been answered early, and the remaining beats are still arriving. The bench provokes this by driving a snoop on the refilling block, or a flush, in the cycle after the early `cpu_done`, while beats are still outstanding. It then judges the outcome at the ports: a second read of the same block must cost four fresh memory beats, which shows the line never became valid.

// File: rtl/assoc2_cache_ctl.sv
module assoc2_cache_ctl #(
  parameter int AW        = 16,
  parameter int DW        = 32,
  parameter int SETS      = 64,
  parameter int WORDS     = 4,
  parameter int EARLY_FWD = 1
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 cpu_req,
  input  logic                 cpu_we,
  input  logic [AW-1:0]        cpu_addr,
  input  logic [DW-1:0]        cpu_wdata,
  output logic [DW-1:0]        cpu_rdata,
  output logic                 cpu_done,
  output logic                 mem_req,
  output logic                 mem_we,
  output logic [AW-1:0]        mem_addr,
  output logic [DW-1:0]        mem_wdata,
  input  logic [DW-1:0]        mem_rdata,
  input  logic                 mem_rdy,
  input  logic                 flush,
  input  logic                 snoop_vld,
  input  logic [AW-5:0]        snoop_blk,
  input  logic                 victim_way,
  output logic                 rpl_touch,
  output logic [$clog2(SETS)-1:0] rpl_set,
  output logic                 rpl_way
);
  localparam int BW   = $clog2(DW/8);
  localparam int WW   = $clog2(WORDS);
  localparam int OFFW = BW + WW;
  localparam int SW   = $clog2(SETS);
  localparam int TW   = AW - SW - OFFW;

  typedef enum logic [1:0] {S_IDLE, S_FILL, S_WR} st_t;
  st_t state;

  logic [TW-1:0]    tag_q [2][SETS];
  logic [DW-1:0]    dat_q [2][SETS][WORDS];
  logic [SETS-1:0]  vld_q [2];

  logic [TW-1:0] f_tag;
  logic [SW-1:0] f_set;
  logic [WW-1:0] f_wrd, beat;
  logic          f_way, f_kill;

  wire [TW-1:0] a_tag = cpu_addr[AW-1 -: TW];
  wire [SW-1:0] a_set = cpu_addr[OFFW +: SW];
  wire [WW-1:0] a_wrd = cpu_addr[BW +: WW];

  wire hit0 = vld_q[0][a_set] && (tag_q[0][a_set] == a_tag);
  wire hit1 = vld_q[1][a_set] && (tag_q[1][a_set] == a_tag);
  wire hit  = hit0 | hit1;
  wire hway = hit1;
  wire [DW-1:0] hdata = dat_q[hway][a_set][a_wrd];

  wire fway = !vld_q[0][a_set] ? 1'b0 : (!vld_q[1][a_set] ? 1'b1 : victim_way);

  wire [TW-1:0] s_tag = snoop_blk[AW-OFFW-1 -: TW];
  wire [SW-1:0] s_set = snoop_blk[SW-1:0];

  wire last     = (beat == WW'(WORDS-1));
  wire fill_rdy = (state == S_FILL) && mem_rdy;
  wire kill_now = flush || (snoop_vld && s_tag == f_tag && s_set == f_set);
  wire rd_hit   = (state == S_IDLE) && cpu_req && !cpu_we && hit;

  assign mem_req   = (state != S_IDLE);
  assign mem_we    = (state == S_WR);
  assign mem_wdata = cpu_wdata;
  assign mem_addr  = (state == S_FILL) ? {f_tag, f_set, beat, {BW{1'b0}}} : cpu_addr;

  assign cpu_rdata = (state == S_FILL) ? mem_rdata : hdata;
  assign cpu_done  = rd_hit
                   || ((state == S_WR) && mem_rdy)
                   || ((EARLY_FWD != 0) && fill_rdy && beat == f_wrd);

  assign rpl_touch = rd_hit || ((state == S_WR) && mem_rdy && hit) || (fill_rdy && last);
  assign rpl_set   = (state == S_FILL) ? f_set : a_set;
  assign rpl_way   = (state == S_FILL) ? f_way : hway;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= S_IDLE;
      vld_q[0] <= '0;
      vld_q[1] <= '0;
      beat     <= '0;
      f_kill   <= 1'b0;
      f_tag    <= '0;
      f_set    <= '0;
      f_wrd    <= '0;
      f_way    <= 1'b0;
    end else begin
      case (state)
        S_IDLE:
          if (cpu_req) begin
            if (cpu_we) state <= S_WR;
            else if (!hit) begin
              f_tag  <= a_tag;
              f_set  <= a_set;
              f_wrd  <= a_wrd;
              f_way  <= fway;
              beat   <= '0;
              f_kill <= 1'b0;
              vld_q[fway][a_set] <= 1'b0;
              state  <= S_FILL;
            end
          end
        S_WR:
          if (mem_rdy) state <= S_IDLE;
        S_FILL: begin
          if (kill_now) f_kill <= 1'b1;
          if (mem_rdy) begin
            beat <= beat + 1'b1;
            if (last) begin
              if (!f_kill && !kill_now) vld_q[f_way][f_set] <= 1'b1;
              state <= S_IDLE;
            end
          end
        end
        default: state <= S_IDLE;
      endcase
      if (snoop_vld) begin
        for (int w = 0; w < 2; w++)
          if (tag_q[w][s_set] == s_tag && !(state == S_FILL && f_way == w[0] && f_set == s_set))
            vld_q[w][s_set] <= 1'b0;
      end
      if (flush) begin
        vld_q[0] <= '0;
        vld_q[1] <= '0;
      end
    end
  end

  always_ff @(posedge clk) begin
    if ((state == S_WR) && mem_rdy && hit) dat_q[hway][a_set][a_wrd] <= cpu_wdata;
    if (fill_rdy) dat_q[f_way][f_set][beat] <= mem_rdata;
    if (fill_rdy && last) tag_q[f_way][f_set] <= f_tag;
  end

  // R11
  mem_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && !mem_rdy |=> mem_req && $stable(mem_addr) && $stable(mem_we));

  // R3
  fill_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fill_rdy && !last |=> (state == S_FILL) &&
      mem_addr[OFFW-1:BW] == WW'($past(mem_addr[OFFW-1:BW]) + 1'b1) &&
      mem_addr[AW-1:OFFW] == $past(mem_addr[AW-1:OFFW]));

  // R5
  wr_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_done && cpu_we |-> mem_rdy && mem_we);

  // R8
  flush_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> vld_q[0] == '0 && vld_q[1] == '0);

  // R7
  one_way_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(hit0 && hit1));
endmodule

// File: tb/test_assoc2_cache_ctl.sv
module test_assoc2_cache_ctl;
  logic clk = 1'b0, rst_n = 1'b0;
  logic cpu_req = 0, cpu_we = 0, mem_rdy = 0, flush = 0, snoop_vld = 0, victim_way = 0;
  logic [15:0] cpu_addr = 0;
  logic [31:0] cpu_wdata = 0, mem_rdata = 0;
  logic [11:0] snoop_blk = 0;
  logic [31:0] cpu_rdata, mem_wdata;
  logic cpu_done, mem_req, mem_we, rpl_touch, rpl_way;
  logic [15:0] mem_addr;
  logic [5:0] rpl_set;

  always #4 clk = ~clk;

  assoc2_cache_ctl i_assoc2_cache_ctl (.*);

  int n_cmp = 0, n_bad = 0, rd_beats = 0, wr_cnt = 0, wait_cnt = 0;
  logic [31:0] mem [int];
  logic [15:0] beat_log [4];

  function automatic logic [31:0] mval(logic [15:0] a);
    int k = int'({a[15:2], 2'b00});
    return mem.exists(k) ? mem[k] : {~a[15:2], 2'b01, a[15:2], 2'b10};
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  initial forever begin
    @(negedge clk);
    if (mem_rdy) begin
      mem_rdy = 0; wait_cnt = 0;
    end else if (mem_req) begin
      if (wait_cnt == 1) begin
        mem_rdy = 1;
        if (mem_we) begin
          mem[int'({mem_addr[15:2], 2'b00})] = mem_wdata; wr_cnt++;
        end else begin
          mem_rdata = mval(mem_addr); beat_log[rd_beats % 4] = mem_addr; rd_beats++;
        end
      end else wait_cnt++;
    end else wait_cnt = 0;
  end

  // inj: 0 none, 1 snoop on same block, 2 flush, injected right after cpu_done
  task automatic do_op(input logic we, input logic [15:0] a, input logic [31:0] wd, input int inj,
                       output logic [31:0] rd, output int beats, output int wrs, output int dbeat);
    int b0 = rd_beats, w0 = wr_cnt;
    @(negedge clk);
    cpu_req = 1; cpu_we = we; cpu_addr = a; cpu_wdata = wd;
    forever begin
      #1;
      if (cpu_done) begin rd = cpu_rdata; dbeat = rd_beats - b0; break; end
      @(negedge clk);
    end
    @(negedge clk);
    cpu_req = 0;
    if (inj == 1) begin snoop_vld = 1; snoop_blk = a[15:4]; end
    if (inj == 2) flush = 1;
    @(negedge clk);
    snoop_vld = 0; flush = 0;
    forever begin #1; if (!mem_req) break; @(negedge clk); end
    beats = rd_beats - b0; wrs = wr_cnt - w0;
  endtask

  localparam int NV = 11;
  localparam logic        V_WE  [NV] = '{0, 0, 0, 0, 1, 0, 1, 0, 0, 0, 0};
  localparam logic [15:0] V_AD  [NV] = '{16'h0124, 16'h0128, 16'h0524, 16'h0120, 16'h0128, 16'h0128,
                                         16'h2200, 16'h2200, 16'h0924, 16'h0124, 16'h0520};
  localparam logic [31:0] V_WD  [NV] = '{0, 0, 0, 0, 32'hDEADBEEF, 0, 32'h12345678, 0, 0, 0, 0};
  localparam logic        V_VIC [NV] = '{0, 0, 0, 0, 0, 0, 0, 0, 1, 0, 0};
  localparam int          V_BT  [NV] = '{4, 0, 4, 0, 0, 0, 0, 4, 4, 0, 4};
  localparam int          V_WR  [NV] = '{0, 0, 0, 0, 1, 0, 1, 0, 0, 0, 0};
  // rows: R3 miss, R2 hit, R7 invalid way first, R1 R2 hit other word, R5 write hit,
  // R2 sees written word, R6 write miss, R6 no allocate, R7 victim input, R7 kept way, R7 evicted way

  task automatic finish_run;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_cmp++; n_bad++;
    $display("FAIL watchdog act=hung exp=finished");
    finish_run();
  end

  initial begin
    logic [31:0] rd;
    int bt, wr, db;
    repeat (3) @(negedge clk);
    rst_n = 1;
    #1;
    chk("R12 mem_req after reset", 32'(mem_req), 0);
    chk("R12 cpu_done after reset", 32'(cpu_done), 0);

    for (int i = 0; i < NV; i++) begin
      victim_way = V_VIC[i];
      do_op(V_WE[i], V_AD[i], V_WD[i], 0, rd, bt, wr, db);
      chk($sformatf("R%0d row %0d beats", V_WE[i] ? 6 : 3, i), 32'(bt), 32'(V_BT[i]));
      chk($sformatf("R%0d row %0d writes", V_WE[i] ? 5 : 2, i), 32'(wr), 32'(V_WR[i]));
      if (!V_WE[i]) chk($sformatf("R2 row %0d data", i), rd, mval(V_AD[i]));
    end
    victim_way = 0;

    do_op(0, 16'h4A38, 0, 0, rd, bt, wr, db);
    chk("R4 early done beat", 32'(db), 3);
    chk("R4 early data", rd, mval(16'h4A38));
    chk("R3 fill beats", 32'(bt), 4);
    for (int k = 0; k < 4; k++) chk("R3 beat address", 32'(beat_log[k]), 32'(16'h4A30 + 4 * k));

    @(negedge clk); flush = 1; @(negedge clk); flush = 0;
    do_op(0, 16'h0124, 0, 0, rd, bt, wr, db);
    chk("R8 refetch after flush", 32'(bt), 4);
    do_op(0, 16'h4A30, 0, 0, rd, bt, wr, db);
    chk("R8 second line refetch", 32'(bt), 4);

    do_op(0, 16'h3330, 0, 0, rd, bt, wr, db);
    @(negedge clk); snoop_vld = 1; snoop_blk = 12'h073; @(negedge clk); snoop_vld = 0;
    do_op(0, 16'h3330, 0, 0, rd, bt, wr, db);
    chk("R9 other tag untouched", 32'(bt), 0);
    @(negedge clk); snoop_vld = 1; snoop_blk = 12'h333; @(negedge clk); snoop_vld = 0;
    do_op(0, 16'h3330, 0, 0, rd, bt, wr, db);
    chk("R9 snooped line refetched", 32'(bt), 4);
    chk("R9 data", rd, mval(16'h3330));

    do_op(0, 16'h1640, 0, 1, rd, bt, wr, db);
    chk("R4 early done on first beat", 32'(db), 1);
    do_op(0, 16'h1640, 0, 0, rd, bt, wr, db);
    chk("R10 snoop during fill", 32'(bt), 4);
    do_op(0, 16'h1680, 0, 2, rd, bt, wr, db);
    do_op(0, 16'h1680, 0, 0, rd, bt, wr, db);
    chk("R10 flush during fill", 32'(bt), 4);
    do_op(0, 16'h1684, 0, 0, rd, bt, wr, db);
    chk("R2 hit after clean fill", 32'(bt), 0);

    finish_run();
  end
endmodule